// File: doc/BRIEF.md
# Constant-Geometry 16-Point FFT Engine

This block computes a 16-point radix-2 discrete Fourier transform on 16-bit signed complex samples. Every stage uses the same hardwired pattern between source and destination words: butterfly k takes words k and k+8 and writes its two results to words 2k and 2k+1. The same wiring therefore serves all four stages. The butterfly cannot update its own source words, so the engine has two buffers that swap roles as source and destination after each stage.

Samples are written in natural order through a load port while the engine is idle. A start pulse then runs the four stages at one butterfly per clock, which is 32 cycles in all. A single-cycle done pulse marks completion. The constant wiring leaves the spectrum in bit-reversed order, so the read port takes a natural bin number and bit-reverses it before it addresses the buffer that holds the result. Each stage halves its outputs, so the result is the DFT divided by 16.

Top module: `cg_fft16`

## Requirements
- R1: After reset, busy and done are low and both buffers are cleared, so every bin reads 0 + 0j.
- R2: While idle, a cycle with ld_en high stores (ld_re, ld_im) at natural sample index ld_idx. Before any transform runs, reading bin b returns the sample stored at index bitrev4(b).
- R3: A start sampled while idle raises busy on the next cycle. After 32 butterfly cycles, done is high for exactly one cycle: it rises 32 clock edges after the edge that sampled start, on the same edge where busy falls.
- R4: After done, bin k reads (1/16)·Σn x[n]·exp(−j2πkn/16) within ±2 LSB on each component, for inputs whose components stay within ±4000.
- R5: The read port is combinational. The 4-bit bin number is bit-reversed (bit 0 swapped with bit 3, bit 1 with bit 2) to form the result-buffer address.
- R6: While busy, ld_en and start are ignored. A load during a run does not change the result, and a start during a run does not restart or lengthen it.
- R7: Each butterfly outputs (a+b+1)>>1 and ((a−b)·W + 2^14)>>15, with W = cos − j·sin held as signed 16-bit numbers with 14 fraction bits. As a result, an impulse of amplitude 16·m at index 0 gives exactly m in every bin, and a constant c gives exactly c in bin 0 and exactly 0 in every other bin.
- R8: In stage s (0..3), butterfly k (0..7) reads source words k and k+8, writes the sum to destination word 2k and the twiddled difference to word 2k+1, and uses twiddle exponent (k>>s)<<s of exp(−j2π/16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Store one input sample this cycle |
| ld_idx | input | 4 | Natural-order sample index |
| ld_re | input | 16 | Sample real part, signed |
| ld_im | input | 16 | Sample imaginary part, signed |
| start | input | 1 | Begin a transform (idle only) |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_bin | input | 4 | Natural frequency bin to read |
| rd_re | output | 16 | Bin real part, signed |
| rd_im | output | 16 | Bin imaginary part, signed |

## Verification
Impulses at index 0 and at an odd index separate the exact halving arithmetic from the twiddle phase progression. A constant input proves that nothing leaks into nonzero bins. Complex tones at bins 1, 7 and 8 each light up a single bin, so a wrong twiddle exponent or a wrong output permutation moves or smears the energy into other bins. Random complex vectors under several seeds exercise all twiddle products together against a DFT computed in floating point. Loads read back before any run expose the bit-reversed read mapping on its own.

// File: rtl/cgfft_pkg.sv
package cgfft_pkg;
  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;
  localparam int HALF  = N / 2;
  localparam int AW    = LOG2N;
  localparam int KW    = LOG2N - 1;
  localparam int SW    = $clog2(LOG2N);
  localparam int DW    = 16;
  localparam int TW    = 16;
  localparam int TFRAC = TW - 2;
  localparam int PW    = DW + TW + 2;
  localparam int NBANK = 2;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cplx_t;

  typedef struct packed {
    logic signed [TW-1:0] c;
    logic signed [TW-1:0] s;
  } tw_t;

  // reverse the order of the address bits
  function automatic logic [AW-1:0] bitrev(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = a[AW-1-i];
    return r;
  endfunction

  // cos / sin of 2*pi*e/N with 14 fraction bits; W = c - j*s
  function automatic tw_t twiddle(input logic [KW-1:0] e);
    tw_t w;
    case (e)
      3'd0: w = '{c:  16'sd16384, s: 16'sd0};
      3'd1: w = '{c:  16'sd15137, s: 16'sd6270};
      3'd2: w = '{c:  16'sd11585, s: 16'sd11585};
      3'd3: w = '{c:  16'sd6270,  s: 16'sd15137};
      3'd4: w = '{c:  16'sd0,     s: 16'sd16384};
      3'd5: w = '{c: -16'sd6270,  s: 16'sd15137};
      3'd6: w = '{c: -16'sd11585, s: 16'sd11585};
      default: w = '{c: -16'sd15137, s: 16'sd6270};
    endcase
    return w;
  endfunction

  // (a+b+1)>>1 on each component
  function automatic cplx_t bf_sum(input cplx_t a, input cplx_t b);
    logic signed [DW:0] sr;
    logic signed [DW:0] si;
    cplx_t y;
    sr = {a.re[DW-1], a.re} + {b.re[DW-1], b.re} + (DW+1)'(1);
    si = {a.im[DW-1], a.im} + {b.im[DW-1], b.im} + (DW+1)'(1);
    y.re = DW'(sr >>> 1);
    y.im = DW'(si >>> 1);
    return y;
  endfunction

  // ((a-b)*W + 2^TFRAC) >> (TFRAC+1)
  function automatic cplx_t bf_diff(input cplx_t a, input cplx_t b, input tw_t w);
    logic signed [DW:0]   dr;
    logic signed [DW:0]   di;
    logic signed [PW-1:0] pr;
    logic signed [PW-1:0] pi;
    cplx_t y;
    dr = {a.re[DW-1], a.re} - {b.re[DW-1], b.re};
    di = {a.im[DW-1], a.im} - {b.im[DW-1], b.im};
    pr = PW'(dr) * PW'(w.c) + PW'(di) * PW'(w.s) + PW'(1 << TFRAC);
    pi = PW'(di) * PW'(w.c) - PW'(dr) * PW'(w.s) + PW'(1 << TFRAC);
    y.re = DW'(pr >>> (TFRAC + 1));
    y.im = DW'(pi >>> (TFRAC + 1));
    return y;
  endfunction
endpackage

// File: rtl/cgfft_bank.sv
module cgfft_bank
  import cgfft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_addr,
  input  cplx_t             ld_data,
  input  logic              bf_we,
  input  logic [KW-1:0]     bf_k,
  input  cplx_t             bf_even,
  input  cplx_t             bf_odd,
  output cplx_t [N-1:0]     words
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
    end else if (ld_we) begin
      words[ld_addr] <= ld_data;
    end else if (bf_we) begin
      words[{bf_k, 1'b0}] <= bf_even;
      words[{bf_k, 1'b1}] <= bf_odd;
    end
  end
endmodule

// File: rtl/cgfft_bfly.sv
module cgfft_bfly
  import cgfft_pkg::*;
(
  input  cplx_t         a,
  input  cplx_t         b,
  input  logic [KW-1:0] tw_exp,
  output cplx_t         y_even,
  output cplx_t         y_odd
);
  tw_t w;
  always_comb begin
    w      = twiddle(tw_exp);
    y_even = bf_sum(a, b);
    y_odd  = bf_diff(a, b, w);
  end
endmodule

// File: rtl/cgfft_seq.sv
module cgfft_seq
  import cgfft_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fire,
  output logic [SW-1:0] stage,
  output logic [KW-1:0] bf_k,
  output logic [KW-1:0] tw_exp,
  output logic          src_sel
);
  localparam logic [KW-1:0] K_LAST = KW'(HALF - 1);
  localparam logic [SW-1:0] S_LAST = SW'(LOG2N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      stage <= '0;
      bf_k  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          stage <= '0;
          bf_k  <= '0;
        end
      end else begin
        bf_k <= bf_k + 1'b1;
        if (bf_k == K_LAST) begin
          stage <= stage + 1'b1;
          if (stage == S_LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    fire    = busy;
    tw_exp  = (bf_k >> stage) << stage;
    src_sel = stage[0];
  end
endmodule

// File: rtl/cg_fft16.sv
module cg_fft16
  import cgfft_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic [AW-1:0]        ld_idx,
  input  logic signed [DW-1:0] ld_re,
  input  logic signed [DW-1:0] ld_im,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic [AW-1:0]        rd_bin,
  output logic signed [DW-1:0] rd_re,
  output logic signed [DW-1:0] rd_im
);
  localparam int FINAL_BANK = LOG2N % NBANK;

  logic          bfly_fire;
  logic [SW-1:0] stage_q;
  logic [KW-1:0] bf_k;
  logic [KW-1:0] tw_exp;
  logic          src_sel;
  logic          dst_sel;
  cplx_t         ld_word;
  cplx_t         op_a;
  cplx_t         op_b;
  cplx_t         res_even;
  cplx_t         res_odd;
  cplx_t         rd_word;
  cplx_t [N-1:0] bank_words [NBANK];

  cgfft_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .fire    (bfly_fire),
    .stage   (stage_q),
    .bf_k    (bf_k),
    .tw_exp  (tw_exp),
    .src_sel (src_sel)
  );

  always_comb begin
    dst_sel    = ~src_sel;
    ld_word.re = ld_re;
    ld_word.im = ld_im;
    if (src_sel) begin
      op_a = bank_words[1][{1'b0, bf_k}];
      op_b = bank_words[1][{1'b1, bf_k}];
    end else begin
      op_a = bank_words[0][{1'b0, bf_k}];
      op_b = bank_words[0][{1'b1, bf_k}];
    end
  end

  cgfft_bfly u_bfly (
    .a      (op_a),
    .b      (op_b),
    .tw_exp (tw_exp),
    .y_even (res_even),
    .y_odd  (res_odd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cgfft_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_we   (ld_en && !busy && (b == 0)),
      .ld_addr (ld_idx),
      .ld_data (ld_word),
      .bf_we   (bfly_fire && (dst_sel == 1'(b))),
      .bf_k    (bf_k),
      .bf_even (res_even),
      .bf_odd  (res_odd),
      .words   (bank_words[b])
    );
  end

  always_comb begin
    rd_word = bank_words[FINAL_BANK][bitrev(rd_bin)];
    rd_re   = rd_word.re;
    rd_im   = rd_word.im;
  end
endmodule

// File: rtl/cg_fft16_checks.sv
module cg_fft16_checks
  import cgfft_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          bfly_fire,
  input logic [SW-1:0] stage
);
  // R3: completion is a single-cycle pulse
  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: done coincides with the end of a run
  a_r3_done_closes_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6: a run only begins from a sampled start
  a_r6_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R8: every run begins at stage 0
  a_r8_first_stage_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (stage == '0));

  // R8: stages advance by at most one per cycle while butterflies fire
  a_r8_stage_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (bfly_fire && $past(bfly_fire)) |->
      ((stage == $past(stage)) || (stage == SW'($past(stage) + 1'b1))));
endmodule

bind cg_fft16 cg_fft16_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .bfly_fire (bfly_fire),
  .stage     (stage_q)
);

// File: tb/tb_cg_fft16.sv
`timescale 1ns/1ps
module tb_cg_fft16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [3:0] ld_idx = '0;
  logic signed [15:0] ld_re = '0;
  logic signed [15:0] ld_im = '0;
  logic start = 1'b0;
  logic busy;
  logic done;
  logic [3:0] rd_bin = '0;
  logic signed [15:0] rd_re;
  logic signed [15:0] rd_im;

  always #2.5 clk = ~clk;

  cg_fft16 dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_re(ld_re), .ld_im(ld_im), .start(start), .busy(busy),
    .done(done), .rd_bin(rd_bin), .rd_re(rd_re), .rd_im(rd_im)
  );

  // kind[31:28]: 0 impulse(idx=p1,amp=p2) 1 constant(amp) 2 tone(bin=p1,amp) 3 random(seed=p1,amp)
  localparam int NVEC = 9;
  localparam logic [31:0] VECS [NVEC] = '{
    {4'd0, 12'd0,  16'd1600},
    {4'd0, 12'd5,  16'd3200},
    {4'd1, 12'd0,  16'd2000},
    {4'd2, 12'd1,  16'd3000},
    {4'd2, 12'd7,  16'd3000},
    {4'd2, 12'd8,  16'd2000},
    {4'd3, 12'd1,  16'd4000},
    {4'd3, 12'd7,  16'd4000},
    {4'd3, 12'd99, 16'd1000}
  };

  int sr [16];
  int si [16];
  real er [16];
  real ei [16];
  int n_chk = 0;
  int n_bad = 0;
  int unsigned rng;
  localparam real PI = 3.14159265358979;

  function automatic int brev4(input int v);
    return ((v & 1) << 3) | ((v & 2) << 1) | ((v & 4) >> 1) | ((v & 8) >> 3);
  endfunction

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next_rand(output int unsigned r);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    r = rng;
  endtask

  task automatic make_input(input logic [31:0] v);
    int kind, p1, p2;
    int unsigned r;
    kind = int'(v[31:28]);
    p1 = int'(v[27:16]);
    p2 = int'(v[15:0]);
    rng = 32'h9E3779B9 ^ p1;
    for (int n = 0; n < 16; n++) begin
      case (kind)
        0: begin sr[n] = (n == p1) ? p2 : 0; si[n] = 0; end
        1: begin sr[n] = p2; si[n] = 0; end
        2: begin
          sr[n] = rnd(p2 * $cos(2.0 * PI * p1 * n / 16.0));
          si[n] = rnd(p2 * $sin(2.0 * PI * p1 * n / 16.0));
        end
        default: begin
          next_rand(r); sr[n] = int'(r % (2 * p2 + 1)) - p2;
          next_rand(r); si[n] = int'(r % (2 * p2 + 1)) - p2;
        end
      endcase
    end
  endtask

  task automatic reference();
    for (int k = 0; k < 16; k++) begin
      er[k] = 0.0; ei[k] = 0.0;
      for (int n = 0; n < 16; n++) begin
        real th;
        th = 2.0 * PI * k * n / 16.0;
        er[k] += sr[n] * $cos(th) + si[n] * $sin(th);
        ei[k] += si[n] * $cos(th) - sr[n] * $sin(th);
      end
      er[k] /= 16.0; ei[k] /= 16.0;
    end
  endtask

  task automatic load_all();
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 4'(n); ld_re = 16'(sr[n]); ld_im = 16'(si[n]);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // start a run; optionally disturb it mid-run with a load and a start
  task automatic run(input string tag, input bit disturb);
    int edges;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({tag, " R3 busy after start"}, int'(busy), 1, 0);
    edges = 0;
    while (!done && edges < 200) begin
      @(negedge clk);
      edges++;
      if (disturb && edges == 10) begin
        ld_en = 1'b1; ld_idx = 4'd0; ld_re = 16'sd30000; ld_im = -16'sd30000; start = 1'b1;
      end else if (disturb && edges == 11) begin
        ld_en = 1'b0; start = 1'b0;
      end
    end
    check({tag, " R3 R6 done edge count"}, edges, 32, 0);
    check({tag, " R3 busy low with done"}, int'(busy), 0, 0);
    @(negedge clk);
    check({tag, " R3 done one cycle"}, int'(done), 0, 0);
  endtask

  task automatic check_bins(input string tag, input int tol);
    for (int k = 0; k < 16; k++) begin
      rd_bin = 4'(k);
      #1;
      check($sformatf("%s bin %0d re", tag, k), int'(rd_re), rnd(er[k]), tol);
      check($sformatf("%s bin %0d im", tag, k), int'(rd_im), rnd(ei[k]), tol);
    end
  endtask

  initial begin
    #750000;
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy), 0, 0);
    check("R1 done", int'(done), 0, 0);
    for (int k = 0; k < 16; k += 5) begin
      rd_bin = 4'(k); #1;
      check("R1 bin re", int'(rd_re), 0, 0);
      check("R1 bin im", int'(rd_im), 0, 0);
    end

    // R4 R8: table of stimulus patterns against the floating-point DFT
    for (int v = 0; v < NVEC; v++) begin
      make_input(VECS[v]);
      reference();
      load_all();
      run($sformatf("vec%0d", v), 1'b0);
      check_bins($sformatf("vec%0d R4 R8", v), 2);
    end

    // R2 R5: loaded samples read back through the bit-reversed port
    for (int n = 0; n < 16; n++) begin sr[n] = 100 * n - 700; si[n] = -7 * n; end
    load_all();
    for (int k = 0; k < 16; k++) begin
      rd_bin = 4'(k); #1;
      check($sformatf("R2 R5 bin %0d re", k), int'(rd_re), sr[brev4(k)], 0);
      check($sformatf("R2 R5 bin %0d im", k), int'(rd_im), si[brev4(k)], 0);
    end

    // R6 R7: impulse at 0, run disturbed by a load and a start; exact result
    for (int n = 0; n < 16; n++) begin sr[n] = (n == 0) ? 1600 : 0; si[n] = 0; end
    load_all();
    run("R6", 1'b1);
    for (int k = 0; k < 16; k++) begin er[k] = 100.0; ei[k] = 0.0; end
    check_bins("R6 R7 impulse exact", 0);

    // R7: constant input gives exact bin 0 and exact zeros
    for (int n = 0; n < 16; n++) begin sr[n] = -1234; si[n] = 2000; end
    load_all();
    run("R7", 1'b0);
    for (int k = 0; k < 16; k++) begin
      er[k] = (k == 0) ? -1234.0 : 0.0;
      ei[k] = (k == 0) ? 2000.0 : 0.0;
    end
    check_bins("R7 constant exact", 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule